// File: doc/BRIEF.md
# Transmit Packet Repeat Sequencer

This block sits between a byte-wide transmit FIFO and a symbol serializer. The host loads one packet image into the FIFO while the block is idle, sets a packet length, a packet count, an inter-packet gap and an exit code, and pulses a start input. The sequencer then hands the bytes to the serializer over a valid/ready handshake. It can repeat the packet several times from that single FIFO load by rewinding the FIFO read pointer to the packet start after each packet, so that the bytes count as unread again.

Between packets the sequencer waits for a programmable number of symbol strobes from the serializer. After the final packet it inserts no gap. It leaves transmit on its own and raises a one-cycle completion pulse carrying the exit code, which tells the surrounding radio controller which state to enter next. If the FIFO runs dry while a packet is still owed, the session ends early and an underflow flag is raised.

The FIFO storage and its pointers are part of the block. Modulation, framing and the host register interface belong to neighbouring logic.

Top module: `tx_repeat_seq`

## Requirements
- R1: While idle, a write strobe stores one byte and raises fifoCount by one. A write is ignored when fifoCount equals DEPTH (16 by default) or when busy is high.
- R2: While idle, fifoFlush empties the FIFO, so fifoCount reads 0 on the following cycle.
- R3: A startTx pulse while idle captures pktLen, pktNum, gapLen, autoRestore and exitSel. Changes to these inputs, and further startTx pulses, have no effect until the session ends.
- R4: In a session, txByte carries the FIFO bytes in write order. Exactly one byte is consumed per cycle in which both txValid and byteReady are high, and txValid is never high while busy is low.
- R5: A pktLen of 0 acts as 1 and a pktNum of 0 acts as 1. A session with enough data transfers exactly pktLen*pktNum bytes.
- R6: With autoRestore = 1, every packet repeats the same first pktLen bytes. After the session, fifoCount equals its value before start.
- R7: With autoRestore = 0, each later packet continues from where the previous packet stopped, and the consumed bytes leave the FIFO.
- R8: Between two consecutive packets exactly gapLen symStrobe pulses are consumed, and txValid stays low during that time. A gapLen of 0 sends the packets back to back. Strobes outside the gap have no effect.
- R9: No gap follows the last packet. done is high in the cycle right after the last byte handshake.
- R10: done is high for exactly one cycle per session, with exitCode equal to the captured exitSel. busy is low on the following cycle.
- R11: If the FIFO is empty while a packet byte is still owed, the session ends: done is high on the next cycle and underflow is set. underflow stays set until the next start, and otherwise reads 0.
- R12: After reset, busy, txValid, done and underflow are low and fifoCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | FIFO write strobe |
| wrData | input | 8 | FIFO write byte |
| fifoFlush | input | 1 | Empty the FIFO (idle only) |
| startTx | input | 1 | Begin a transmit session |
| pktLen | input | 8 | Bytes per packet, 0 means 1 |
| pktNum | input | 8 | Packets per session, 0 means 1 |
| gapLen | input | 8 | Symbol strobes between packets |
| autoRestore | input | 1 | Rewind read pointer after each packet |
| exitSel | input | 2 | Exit code to report at completion |
| symStrobe | input | 1 | One pulse per symbol period |
| byteReady | input | 1 | Serializer accepts a byte |
| txByte | output | 8 | Byte offered to the serializer |
| txValid | output | 1 | txByte is valid |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle completion pulse |
| exitCode | output | 2 | Captured exit code, valid with done |
| underflow | output | 1 | Session ended on an empty FIFO |
| fifoCount | output | 5 | Unread bytes in the FIFO |

## Verification
A wrong read pointer shows up on txByte at the first handshake that follows the bad rewind or pop, so each transferred byte is compared with the value the bench derives from the write pattern. A byte or packet counter that drifts shows up as a byte total that differs from pktLen*pktNum, or as done arriving more or less than one cycle after the final handshake. A wrong gap counter shows up as the wrong number of strobes between packets. A lost or stuck restore shows up on fifoCount once the session returns to idle.

// File: rtl/txrep_pkg.sv
package txrep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_GAP,
    ST_DONE
  } seqState_t;

  // strobes from control to FIFO datapath
  typedef struct packed {
    logic markStart;
    logic popByte;
    logic rewind;
    logic flush;
  } fifoCtl_t;

endpackage

// File: rtl/txrep_fifo.sv
module txrep_fifo
  import txrep_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     busy,
  input  fifoCtl_t                 ctl,
  output logic [DATA_W-1:0]        rdData,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   count
);

  localparam int PW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW:0] wrPtr, rdPtr, startPtr;
  logic wrAccept;

  assign count    = wrPtr - rdPtr;
  assign empty    = (count == '0);
  assign wrAccept = wrEn && !busy && !ctl.flush && (count != (PW+1)'(DEPTH));
  assign rdData   = mem[rdPtr[PW-1:0]];

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrPtr[PW-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      startPtr <= '0;
    end else if (ctl.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      startPtr <= '0;
    end else begin
      if (wrAccept)       wrPtr <= wrPtr + 1'b1;
      if (ctl.rewind)     rdPtr <= startPtr;
      else if (ctl.popByte) rdPtr <= rdPtr + 1'b1;
      if (ctl.markStart)  startPtr <= rdPtr;
    end
  end

endmodule

// File: rtl/txrep_ctrl.sv
module txrep_ctrl
  import txrep_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int EXIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startTx,
  input  logic              fifoFlush,
  input  logic [CFG_W-1:0]  pktLen,
  input  logic [CFG_W-1:0]  pktNum,
  input  logic [CFG_W-1:0]  gapLen,
  input  logic              autoRestore,
  input  logic [EXIT_W-1:0] exitSel,
  input  logic              symStrobe,
  input  logic              byteReady,
  input  logic              fifoEmpty,
  output fifoCtl_t          ctl,
  output logic              txValid,
  output logic              busy,
  output logic              done,
  output logic [EXIT_W-1:0] exitCode,
  output logic              underflow
);

  localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

  seqState_t state;
  logic [CFG_W-1:0] lenR, numR, gapR;
  logic [CFG_W-1:0] byteCnt, pktCnt, gapCnt;
  logic [EXIT_W-1:0] exitR;
  logic restoreR, ufR;
  logic handshake, lastByte, lastPkt, launch;

  assign launch    = (state == ST_IDLE) && startTx;
  assign txValid   = (state == ST_SEND) && !fifoEmpty;
  assign handshake = txValid && byteReady;
  assign lastByte  = (byteCnt == lenR - ONE);
  assign lastPkt   = (pktCnt == numR - ONE);

  always_comb begin
    ctl           = '0;
    ctl.markStart = launch;
    ctl.flush     = (state == ST_IDLE) && fifoFlush && !startTx;
    ctl.rewind    = handshake && lastByte && restoreR;
    ctl.popByte   = handshake && !(lastByte && restoreR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lenR     <= ONE;
      numR     <= ONE;
      gapR     <= '0;
      exitR    <= '0;
      restoreR <= 1'b0;
      ufR      <= 1'b0;
      byteCnt  <= '0;
      pktCnt   <= '0;
      gapCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            lenR     <= (pktLen == '0) ? ONE : pktLen;
            numR     <= (pktNum == '0) ? ONE : pktNum;
            gapR     <= gapLen;
            exitR    <= exitSel;
            restoreR <= autoRestore;
            ufR      <= 1'b0;
            byteCnt  <= '0;
            pktCnt   <= '0;
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fifoEmpty) begin
            ufR   <= 1'b1;
            state <= ST_DONE;
          end else if (handshake) begin
            if (lastByte) begin
              byteCnt <= '0;
              if (lastPkt) begin
                state <= ST_DONE;
              end else begin
                pktCnt <= pktCnt + ONE;
                gapCnt <= '0;
                state  <= (gapR == '0) ? ST_SEND : ST_GAP;
              end
            end else begin
              byteCnt <= byteCnt + ONE;
            end
          end
        end
        ST_GAP: begin
          if (symStrobe) begin
            if (gapCnt == gapR - ONE) state <= ST_SEND;
            else gapCnt <= gapCnt + ONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign exitCode  = exitR;
  assign underflow = ufR;

endmodule

// File: rtl/tx_repeat_seq.sv
module tx_repeat_seq
  import txrep_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CFG_W  = 8,
  parameter int EXIT_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   fifoFlush,
  input  logic                   startTx,
  input  logic [CFG_W-1:0]       pktLen,
  input  logic [CFG_W-1:0]       pktNum,
  input  logic [CFG_W-1:0]       gapLen,
  input  logic                   autoRestore,
  input  logic [EXIT_W-1:0]      exitSel,
  input  logic                   symStrobe,
  input  logic                   byteReady,
  output logic [DATA_W-1:0]      txByte,
  output logic                   txValid,
  output logic                   busy,
  output logic                   done,
  output logic [EXIT_W-1:0]      exitCode,
  output logic                   underflow,
  output logic [$clog2(DEPTH):0] fifoCount
);

  fifoCtl_t ctl;
  logic fifoEmpty;

  txrep_ctrl #(.CFG_W(CFG_W), .EXIT_W(EXIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startTx(startTx), .fifoFlush(fifoFlush),
    .pktLen(pktLen), .pktNum(pktNum), .gapLen(gapLen),
    .autoRestore(autoRestore), .exitSel(exitSel), .symStrobe(symStrobe),
    .byteReady(byteReady), .fifoEmpty(fifoEmpty), .ctl(ctl),
    .txValid(txValid), .busy(busy), .done(done), .exitCode(exitCode),
    .underflow(underflow)
  );

  txrep_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .busy(busy),
    .ctl(ctl), .rdData(txByte), .empty(fifoEmpty), .count(fifoCount)
  );

endmodule

// File: rtl/tx_repeat_seq_chk.sv
module tx_repeat_seq_chk #(
  parameter int DEPTH  = 16,
  parameter int EXIT_W = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   txValid,
  input logic                   busy,
  input logic                   done,
  input logic                   underflow,
  input logic [EXIT_W-1:0]      exitCode,
  input logic [$clog2(DEPTH):0] fifoCount
);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R4
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);

  // R11
  underflow_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underflow) |-> done);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= ($clog2(DEPTH)+1)'(DEPTH));

  // R4
  valid_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (fifoCount != '0));

  // R3
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(exitCode));

endmodule

bind tx_repeat_seq tx_repeat_seq_chk #(.DEPTH(DEPTH), .EXIT_W(EXIT_W)) u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .busy(busy), .done(done),
  .underflow(underflow), .exitCode(exitCode), .fifoCount(fifoCount)
);

// File: tb/tb_tx_repeat_seq.sv
module tb_tx_repeat_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, fifoFlush = 1'b0, startTx = 1'b0;
  logic [7:0] wrData = '0, pktLen = '0, pktNum = '0, gapLen = '0;
  logic autoRestore = 1'b0;
  logic [1:0] exitSel = '0;
  logic symStrobe = 1'b0, byteReady = 1'b0;
  logic [7:0] txByte;
  logic txValid, busy, done, underflow;
  logic [1:0] exitCode;
  logic [4:0] fifoCount;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tx_repeat_seq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .fifoFlush(fifoFlush),
    .startTx(startTx), .pktLen(pktLen), .pktNum(pktNum), .gapLen(gapLen),
    .autoRestore(autoRestore), .exitSel(exitSel), .symStrobe(symStrobe),
    .byteReady(byteReady), .txByte(txByte), .txValid(txValid), .busy(busy),
    .done(done), .exitCode(exitCode), .underflow(underflow), .fifoCount(fifoCount)
  );

  typedef struct packed {
    logic [7:0]  nBytes;
    logic [7:0]  len;
    logic [7:0]  num;
    logic [7:0]  gap;
    logic        restore;
    logic [1:0]  exitV;
    logic        stall;
    logic [15:0] expTotal;
    logic        expUf;
    logic [7:0]  expLeft;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  8'd4,  8'd3, 8'd2, 1'b1, 2'd2, 1'b0, 16'd12, 1'b0, 8'd8},
    '{8'd12, 8'd4,  8'd3, 8'd0, 1'b0, 2'd1, 1'b0, 16'd12, 1'b0, 8'd0},
    '{8'd10, 8'd3,  8'd2, 8'd1, 1'b0, 2'd3, 1'b0, 16'd6,  1'b0, 8'd4},
    '{8'd5,  8'd0,  8'd0, 8'd3, 1'b1, 2'd0, 1'b0, 16'd1,  1'b0, 8'd5},
    '{8'd6,  8'd4,  8'd2, 8'd1, 1'b0, 2'd2, 1'b0, 16'd6,  1'b1, 8'd0},
    '{8'd3,  8'd4,  8'd2, 8'd1, 1'b1, 2'd1, 1'b0, 16'd3,  1'b1, 8'd0},
    '{8'd0,  8'd2,  8'd1, 8'd0, 1'b0, 2'd3, 1'b0, 16'd0,  1'b1, 8'd0},
    '{8'd16, 8'd16, 8'd2, 8'd4, 1'b1, 2'd0, 1'b1, 16'd32, 1'b0, 8'd16},
    '{8'd7,  8'd7,  8'd1, 8'd5, 1'b0, 2'd1, 1'b0, 16'd7,  1'b0, 8'd0},
    '{8'd9,  8'd3,  8'd3, 8'd1, 1'b0, 2'd2, 1'b1, 16'd9,  1'b0, 8'd0}
  };

  function automatic logic [7:0] pat(int r, int i);
    return 8'((r * 16) + (i * 3) + 7);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic runRow(input int r);
    vec_t v = VECS[r];
    int effLen = (v.len == 0) ? 1 : int'(v.len);
    int effNum = (v.num == 0) ? 1 : int'(v.num);
    int hs = 0, gapSeen = 0, lastHs = -10, doneCnt = 0;
    bit between = 1'b0, lastBusy = 1'b0, lastDone = 1'b0;
    // R2: flush
    cyc(); fifoFlush = 1'b1;
    cyc(); fifoFlush = 1'b0;
    for (int i = 0; i < int'(v.nBytes); i++) begin
      wrEn = 1'b1; wrData = pat(r, i);
      cyc();
    end
    wrEn = 1'b0;
    @(negedge clk);
    check(fifoCount == 5'(v.nBytes), "R1 load count", fifoCount, v.nBytes);
    cyc();
    startTx = 1'b1; pktLen = v.len; pktNum = v.num; gapLen = v.gap;
    autoRestore = v.restore; exitSel = v.exitV;
    for (int c = 0; c < 600; c++) begin
      cyc();
      // R3: scrambled settings and repeated start while busy
      startTx = lastBusy && !lastDone;
      pktLen = 8'd1; pktNum = 8'd1; gapLen = 8'd0;
      autoRestore = ~v.restore; exitSel = ~v.exitV;
      wrEn = lastBusy && !lastDone; wrData = 8'hEE;
      byteReady = v.stall ? c[0] : 1'b1;
      symStrobe = (c % 3 == 0);
      @(negedge clk);
      if (txValid && byteReady) begin
        int idx = v.restore ? (hs % effLen) : hs;
        // R4 R6 R7
        check(txByte == pat(r, idx), "R4 byte order", txByte, pat(r, idx));
        hs++;
        lastHs = c;
        between = (hs % effLen == 0) && (hs < effLen * effNum);
      end else if (between && symStrobe) begin
        gapSeen++;
      end
      if (done) begin
        doneCnt++;
        check(exitCode == v.exitV, "R10 exit code", exitCode, v.exitV);
        check(underflow == v.expUf, "R11 underflow at done", underflow, v.expUf);
        if (!v.expUf) check(c == lastHs + 1, "R9 done after last byte", c, lastHs + 1);
      end
      lastBusy = busy; lastDone = done;
      if (!busy && doneCnt > 0) break;
    end
    check(doneCnt == 1, "R10 one done pulse", doneCnt, 1);
    check(hs == int'(v.expTotal), "R5 byte total", hs, v.expTotal);
    check(fifoCount == 5'(v.expLeft), "R6 R7 fifo left", fifoCount, v.expLeft);
    check(underflow == v.expUf, "R11 underflow held", underflow, v.expUf);
    if (!v.stall && !v.expUf)
      check(gapSeen == int'(v.gap) * (effNum - 1), "R8 gap strobes", gapSeen,
            int'(v.gap) * (effNum - 1));
    cyc();
    startTx = 1'b0; wrEn = 1'b0; byteReady = 1'b0; symStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(!busy && !txValid && !done, "R12 reset outputs", {busy, txValid, done}, 0);
    check(!underflow && fifoCount == 0, "R12 reset fifo", fifoCount, 0);
    cyc(); rstN = 1'b1;
    for (int r = 0; r < NV; r++) runRow(r);
    // R1: writes beyond DEPTH are ignored
    cyc(); fifoFlush = 1'b1;
    cyc(); fifoFlush = 1'b0;
    for (int i = 0; i < 18; i++) begin
      wrEn = 1'b1; wrData = 8'(i);
      cyc();
    end
    wrEn = 1'b0;
    @(negedge clk);
    check(fifoCount == 5'd16, "R1 full ignore", fifoCount, 16);
    // R2: flush while idle
    cyc(); fifoFlush = 1'b1;
    cyc(); fifoFlush = 1'b0;
    @(negedge clk);
    check(fifoCount == 5'd0, "R2 flush", fifoCount, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule